// File: doc/BRIEF.md
# Parallel-Load Serial Shift Register

This block is an eight-stage (by default) shift register that runs on a fast system clock. It takes a whole word from its parallel inputs while the load control is held low. Once the load control is high, each rising edge of the shift clock moves the contents one stage toward the last stage, and the serial input enters the first stage. The last stage is driven out together with its logical complement.

The shift-clock pin and the clock-inhibit pin are ordinary asynchronous inputs. They are brought into the system-clock domain by a two-flop synchronizer and combined by an OR. This is the inverse of a NOR gate, so the rising edge of the combined signal is the shift event. Because of this, either pin can serve as the clock while the other is held low, and holding either pin high blocks shifting. The load control is synchronized in the same way. An illegal rise of the inhibit pin while the clock pin is low sets a sticky flag, because that rise would itself look like a clock edge.

Top module: `piso_shift_reg`

## Requirements
- R1: After rst_ni is low, every stage is 0: q_o reads 0, q_no reads 1 and order_err_o reads 0.
- R2: While load_ni is low, stage k takes par_i[k]. Stage 0 is the first stage and stage WIDTH-1 drives q_o, so q_o shows par_i[WIDTH-1] after a load.
- R3: While load_ni is low, activity on sclk_i, inh_i and ser_i has no effect. The contents after load_ni is released equal par_i.
- R4: With load_ni high and inh_i low, a low-to-high change of sclk_i moves stage k into stage k+1, once per edge.
- R5: On each shift, ser_i enters stage 0. After WIDTH shifts, q_o presents the serial bits in the order they were applied.
- R6: While inh_i is high, transitions of sclk_i do not shift the register.
- R7: With load_ni high and no rising edge on the OR of sclk_i and inh_i, all stages keep their values.
- R8: With sclk_i held low, a rising edge of inh_i shifts exactly like a rising edge of sclk_i.
- R9: q_no is always the complement of q_o.
- R10: order_err_o goes to 1 when inh_i rises while sclk_i is low. It stays at 1 until reset and never goes to 1 while that ordering is obeyed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Load control; low copies par_i into the stages |
| par_i | input | WIDTH | Parallel data, bit k to stage k |
| ser_i | input | 1 | Serial data into stage 0 |
| sclk_i | input | 1 | Shift clock pin (asynchronous) |
| inh_i | input | 1 | Clock inhibit pin (asynchronous) |
| q_o | output | 1 | Last stage |
| q_no | output | 1 | Complement of last stage |
| order_err_o | output | 1 | Sticky flag for an illegal inhibit rise |

## Verification
The assertions assume that par_i and ser_i are steady for the few system cycles around any change of load_ni or of the clock pins. These two inputs are sampled without a synchronizer, in the cycle where the synchronized control acts. The stimulus changes pins only on falling system-clock edges. It holds every pin level for four system cycles, which exceeds the three-cycle synchronizer-plus-register path. It also sets par_i and ser_i before the control pin that uses them and leaves them unchanged until the next operation. Illegal inhibit rises appear only in one directed phase, which is followed by a reset.

// File: rtl/piso_pkg.sv
package piso_pkg;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned SYNC_BITS  = 3;  // load, clock, inhibit
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int unsigned N     = 3,
  parameter int unsigned DEPTH = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] pipe [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) pipe[k] <= RST_VAL;
    end else begin
      pipe[0] <= d_i;
      for (int k = 1; k < DEPTH; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign q_o = pipe[DEPTH-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ck_i,
  input  logic inh_i,
  input  logic load_n_i,
  output logic shift_o,
  output logic order_err_o
);
  logic en_clk, en_q, inh_q, err_q;

  // complement of the NOR: its rise is the shift event
  assign en_clk = ck_i | inh_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      inh_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      en_q  <= en_clk;
      inh_q <= inh_i;
      if (inh_i && !inh_q && !ck_i) err_q <= 1'b1;
    end
  end

  assign shift_o     = en_clk & ~en_q & load_n_i;
  assign order_err_o = err_q;

  a_r3_no_shift_in_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_n_i |-> !shift_o);
  a_r6_inhibit_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_i && inh_q) |-> !shift_o);
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    order_err_o |=> order_err_o);
endmodule

// File: rtl/piso_stages.sv
module piso_stages #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_n_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  output logic             q_o,
  output logic             q_no
);
  logic [WIDTH-1:0] st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       st <= '0;
    else if (!load_n_i) st <= par_i;
    else if (shift_i)  st <= {st[WIDTH-2:0], ser_i};
  end

  assign q_o  = st[WIDTH-1];
  assign q_no = ~st[WIDTH-1];

  a_r2_load_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_n_i |=> (st == $past(par_i)));
  a_r4_shift_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_n_i && shift_i) |=> (st == {$past(st[WIDTH-2:0]), $past(ser_i)}));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_n_i && !shift_i) |=> $stable(st));
  a_r9_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_no == !q_o);
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  input  logic             sclk_i,
  input  logic             inh_i,
  output logic             q_o,
  output logic             q_no,
  output logic             order_err_o
);
  import piso_pkg::*;

  logic [SYNC_BITS-1:0] raw, synced;
  logic shift;

  assign raw = {load_ni, sclk_i, inh_i};

  // load idles high so reset does not trigger a load
  piso_sync #(
    .N(SYNC_BITS), .DEPTH(SYNC_DEPTH), .RST_VAL(3'b100)
  ) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(synced)
  );

  piso_edge i_edge (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ck_i(synced[1]), .inh_i(synced[0]), .load_n_i(synced[2]),
    .shift_o(shift), .order_err_o(order_err_o)
  );

  piso_stages #(.WIDTH(WIDTH)) i_stages (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_n_i(synced[2]), .shift_i(shift),
    .par_i(par_i), .ser_i(ser_i),
    .q_o(q_o), .q_no(q_no)
  );
endmodule

// File: tb/test_piso_shift_reg.sv
module test_piso_shift_reg;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic load_ni = 1'b1;
  logic [W-1:0] par_i = '0;
  logic ser_i = 1'b0, sclk_i = 1'b0, inh_i = 1'b0;
  logic q_o, q_no, order_err_o;

  int checks = 0, errors = 0;
  logic [W-1:0] m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  piso_shift_reg #(.WIDTH(W)) i_piso_shift_reg (
    .clk_i(clk), .rst_ni(rst_ni), .load_ni(load_ni), .par_i(par_i),
    .ser_i(ser_i), .sclk_i(sclk_i), .inh_i(inh_i),
    .q_o(q_o), .q_no(q_no), .order_err_o(order_err_o)
  );

  function automatic logic [W-1:0] shifted(logic [W-1:0] v, logic s);
    return {v[W-2:0], s};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_out(string req);
    chk(req, {7'd0, q_o}, {7'd0, m[W-1]});
    chk("R9", {7'd0, q_no}, {7'd0, ~m[W-1]});
  endtask

  task automatic do_load(logic [W-1:0] v);
    par_i = v; load_ni = 1'b0; wait_cyc(HOLD);
    load_ni = 1'b1; wait_cyc(HOLD);
    m = v;
  endtask

  task automatic clk_pulse(logic s);
    ser_i = s; sclk_i = 1'b1; wait_cyc(HOLD);
    sclk_i = 1'b0; wait_cyc(HOLD);
    m = shifted(m, s);
  endtask

  // one legal shift, then a blocked clock pulse under inhibit
  task automatic inhibited_pulse(logic s);
    ser_i = s; sclk_i = 1'b1; wait_cyc(HOLD);
    m = shifted(m, s);
    inh_i = 1'b1; wait_cyc(HOLD);
    ser_i = ~s;
    sclk_i = 1'b0; wait_cyc(HOLD);
    sclk_i = 1'b1; wait_cyc(HOLD);
    inh_i = 1'b0; wait_cyc(HOLD);
    sclk_i = 1'b0; wait_cyc(HOLD);
  endtask

  task automatic read_out(string req);
    for (int i = 0; i < W; i++) begin
      check_out(req);
      clk_pulse(1'b0);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; load_ni = 1'b1; sclk_i = 1'b0; inh_i = 1'b0;
    wait_cyc(3); rst_ni = 1'b1; wait_cyc(HOLD);
    m = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    do_reset();
    // R1 reset state
    chk("R1", {7'd0, q_o}, 8'd0);
    chk("R1", {7'd0, q_no}, 8'd1);
    chk("R1", {7'd0, order_err_o}, 8'd0);

    // R3 clock and serial activity during load are ignored
    par_i = 8'hA5; load_ni = 1'b0; wait_cyc(HOLD);
    for (int i = 0; i < 3; i++) begin
      ser_i = ~ser_i; sclk_i = 1'b1; wait_cyc(HOLD);
      sclk_i = 1'b0; wait_cyc(HOLD);
    end
    load_ni = 1'b1; wait_cyc(HOLD);
    m = 8'hA5;
    read_out("R3");

    // R5 serial bits appear in order after W shifts
    begin
      logic [W-1:0] pat = 8'h2D;
      for (int i = W-1; i >= 0; i--) clk_pulse(pat[i]);
      read_out("R5");
    end

    // R2 and R4 direct load and shift-out
    do_load(8'h81); read_out("R2");
    do_load(8'h7E); read_out("R4");

    // R6 inhibit blocks clock transitions
    do_load(8'hC3);
    inhibited_pulse(1'b1);
    read_out("R6");
    chk("R10", {7'd0, order_err_o}, 8'd0);

    // R7 idle with serial toggling keeps contents
    do_load(8'h5A);
    for (int i = 0; i < 10; i++) begin ser_i = ~ser_i; wait_cyc(2); end
    read_out("R7");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op = $urandom % 4;
      logic s = 1'($urandom);
      case (op)
        0: do_load(W'($urandom));
        1: clk_pulse(s);
        2: inhibited_pulse(s);
        default: begin ser_i = s; wait_cyc(HOLD); end
      endcase
      check_out("R4");
    end
    chk("R10", {7'd0, order_err_o}, 8'd0);

    // R8 inhibit pin used as clock with clock pin low
    do_load(8'h96);
    ser_i = 1'b1; inh_i = 1'b1; wait_cyc(HOLD);
    inh_i = 1'b0; wait_cyc(HOLD);
    m = shifted(m, 1'b1);
    chk("R10", {7'd0, order_err_o}, 8'd1);
    ser_i = 1'b0; inh_i = 1'b1; wait_cyc(HOLD);
    inh_i = 1'b0; wait_cyc(HOLD);
    m = shifted(m, 1'b0);
    check_out("R8");
    read_out("R8");
    chk("R10", {7'd0, order_err_o}, 8'd1);

    // R1 reset clears the sticky flag and stages
    do_reset();
    chk("R1", {7'd0, order_err_o}, 8'd0);
    chk("R1", {7'd0, q_o}, 8'd0);
    chk("R1", {7'd0, q_no}, 8'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule